// File: doc/BRIEF.md
# Burst Word Address Generator

This block supplies the word address for each access of a four-word burst. When a burst begins, the whole external address is captured. That address is the first access. Its two low bits are also kept as the burst start. Each later clock with the active-low advance input asserted steps a two-bit position counter. The low address bits are then formed from the start bits and the position.

A mode input picks one of two orders. In interleaved order the start bits are XORed with the position. In linear order the position is added to the start bits, modulo four. The upper address bits are not touched during the burst. A cycle decoder outside this block decides when to load and when to advance. Read and write bursts step the same way.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `accessAddr` is all zeros.
- R2: A clock edge with `loadReq` high makes `accessAddr` equal to the sampled `extAddr` from the next cycle on. The burst position restarts at 0.
- R3: With `modeIlv` = 1 the low two bits follow the interleaved order. Start 0 gives 0,1,2,3. Start 1 gives 1,0,3,2. Start 2 gives 2,3,0,1. Start 3 gives 3,2,1,0.
- R4: With `modeIlv` = 0 the low two bits follow the linear order. From start s they run s, s+1, s+2, s+3, all modulo 4 (for example 1,2,3,0).
- R5: A clock edge with `advanceN` low and `loadReq` low steps the burst one position. After four steps the low bits are back at the start value.
- R6: When `loadReq` is high and `advanceN` is low at the same edge, the load wins. The next address is `extAddr` and not a stepped address.
- R7: A clock edge with `loadReq` low and `advanceN` high leaves `accessAddr` unchanged, as long as `modeIlv` is also unchanged.
- R8: Bits above bit 1 keep their loaded value for the whole burst. Values on `extAddr` at edges without `loadReq` have no effect.
- R9: `modeIlv` acts combinationally on the current position. Changing it in the middle of a burst makes the other order's element at the same position appear at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| loadReq | input | 1 | Begin a burst from `extAddr` |
| extAddr | input | ADDR_W | External start address |
| advanceN | input | 1 | Active-low step request |
| modeIlv | input | 1 | 1 = interleaved order, 0 = linear order |
| accessAddr | output | ADDR_W | Current access word address |

## Verification
The bench runs full bursts from all four start values in both orders, plus a fifth step to check the wrap. A design that treated the orders as the same, or stepped by XOR in both modes, would give the wrong word at the second or fourth access from starts 1 and 3.

The bench also asserts load and advance together. A design that gave the step priority would show an address one position past `extAddr`. Random values are driven onto `extAddr` while a burst advances. Leaking upper bits would show at once as a wrong high address. Mode is flipped in the middle of a burst, and a design that latched the mode at load would keep the old order.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef struct packed {
    logic loadEn;
    logic stepEn;
  } burstStrobe_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic         loadReq,
  input  logic         advanceN,
  output burstStrobe_t strobe
);
  // load dominates; a step happens only when no load is requested
  always_comb begin
    strobe.loadEn = loadReq;
    strobe.stepEn = !loadReq && !advanceN;
  end
endmodule

// File: rtl/burst_dpath.sv
module burst_dpath
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobe_t      strobe,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              modeIlv,
  output logic [ADDR_W-1:0] accessAddr
);
  localparam int LOW_W  = $clog2(BURST_LEN);
  localparam int HIGH_W = ADDR_W - LOW_W;

  logic [LOW_W-1:0] startQ;
  logic [LOW_W-1:0] posQ;
  logic [LOW_W-1:0] lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      posQ   <= '0;
    end else if (strobe.loadEn) begin
      startQ <= extAddr[LOW_W-1:0];
      posQ   <= '0;
    end else if (strobe.stepEn) begin
      posQ   <= posQ + LOW_W'(1);
    end
  end

  always_comb begin
    if (modeIlv) lowBits = startQ ^ posQ;
    else         lowBits = startQ + posQ;
  end

  generate
    if (HIGH_W > 0) begin : g_upper
      logic [HIGH_W-1:0] upperQ;
      always_ff @(posedge clk) begin
        if (!rstN)               upperQ <= '0;
        else if (strobe.loadEn)  upperQ <= extAddr[ADDR_W-1:LOW_W];
      end
      assign accessAddr = {upperQ, lowBits};
    end else begin : g_noupper
      assign accessAddr = lowBits;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadReq,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              advanceN,
  input  logic              modeIlv,
  output logic [ADDR_W-1:0] accessAddr
);
  burstStrobe_t strobe;

  burst_ctrl u_ctrl (
    .loadReq (loadReq),
    .advanceN(advanceN),
    .strobe  (strobe)
  );

  burst_dpath #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .extAddr   (extAddr),
    .modeIlv   (modeIlv),
    .accessAddr(accessAddr)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W    = 16,
  parameter int BURST_LEN = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadReq,
  input logic [ADDR_W-1:0] extAddr,
  input logic              advanceN,
  input logic              modeIlv,
  input logic [ADDR_W-1:0] accessAddr
);
  localparam int LOW_W = $clog2(BURST_LEN);

  // R2: a load presents the captured address next cycle
  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadReq |=> accessAddr == $past(extAddr));

  // R6: load beats a simultaneous advance
  assert_load_priority_R6: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && !advanceN) |=> accessAddr == $past(extAddr));

  // R7: idle edge with steady mode holds the address
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!loadReq && advanceN) |=> (!$stable(modeIlv) || $stable(accessAddr)));

  // R8: upper bits only change on a load
  assert_upper_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !loadReq |=> accessAddr[ADDR_W-1:LOW_W] == $past(accessAddr[ADDR_W-1:LOW_W]));

  // R4: a linear step adds one to the low bits
  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!loadReq && !advanceN && !modeIlv) |=>
      (modeIlv || accessAddr[LOW_W-1:0] == LOW_W'($past(accessAddr[LOW_W-1:0]) + 1)));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_chk (.*);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadReq = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic          advanceN = 1'b1;
  logic          modeIlv = 1'b1;
  logic [AW-1:0] accessAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int refUpper = 0;
  int refStart = 0;
  int refPos = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) u0 (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .extAddr(extAddr),
    .advanceN(advanceN), .modeIlv(modeIlv), .accessAddr(accessAddr)
  );

  function automatic int ilvOrder(int s, int k);
    int r;
    case (s)
      0: r = k;
      1: case (k) 0: r = 1; 1: r = 0; 2: r = 3; default: r = 2; endcase
      2: case (k) 0: r = 2; 1: r = 3; 2: r = 0; default: r = 1; endcase
      default: case (k) 0: r = 3; 1: r = 2; 2: r = 1; default: r = 0; endcase
    endcase
    return r;
  endfunction

  function automatic int expAddr();
    int low;
    low = modeIlv ? ilvOrder(refStart, refPos) : (refStart + refPos) % 4;
    return refUpper * 4 + low;
  endfunction

  task automatic compare(string tag);
    int e;
    e = expAddr();
    checks++;
    if (int'(accessAddr) != e) begin
      errors++;
      $display("FAIL %s: accessAddr=%h expected=%h", tag, accessAddr, e[AW-1:0]);
    end
  endtask

  // one clock: update model at the edge, compare at the falling edge
  task automatic tick(string tag);
    @(posedge clk);
    if (!rstN) begin
      refUpper = 0; refStart = 0; refPos = 0;
    end else if (loadReq) begin
      refUpper = int'(extAddr) / 4;
      refStart = int'(extAddr) % 4;
      refPos = 0;
    end else if (!advanceN) begin
      refPos = (refPos + 1) % 4;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic runBurst(logic [AW-1:0] a, logic m, string tag);
    modeIlv = m; loadReq = 1; extAddr = a; advanceN = 1;
    tick("R2");
    loadReq = 0;
    for (int i = 0; i < 4; i++) begin
      advanceN = 0;
      extAddr = AW'($urandom);
      tick(tag);
    end
    advanceN = 1;
  endtask

  initial begin
    repeat (3) tick("R1");
    rstN = 1;
    tick("R1");

    // R3 / R5: interleaved bursts from every start, with wrap
    for (int s = 0; s < 4; s++) runBurst(AW'(16'h1230 + s), 1'b1, "R3_R5");
    // R4 / R5: linear bursts from every start, with wrap
    for (int s = 0; s < 4; s++) runBurst(AW'(16'hABC4 + s), 1'b0, "R4_R5");

    // R6: load and advance together
    modeIlv = 0; loadReq = 1; advanceN = 0; extAddr = 16'h7771;
    tick("R6");
    loadReq = 1; advanceN = 0; extAddr = 16'h0F02;
    tick("R6");
    loadReq = 0;

    // R7: hold with no load and no advance, extAddr changing (R8)
    advanceN = 0; tick("R5");
    advanceN = 1;
    for (int i = 0; i < 3; i++) begin
      extAddr = AW'($urandom);
      tick("R7_R8");
    end

    // R9: mode flip mid-burst, seen combinationally
    modeIlv = 1; loadReq = 1; extAddr = 16'h5553; advanceN = 1;
    tick("R2");
    loadReq = 0; advanceN = 0;
    tick("R3");
    modeIlv = 0;
    #1 compare("R9");
    tick("R9");
    modeIlv = 1;
    #1 compare("R9");
    advanceN = 1;
    tick("R9");

    // random mixed traffic against the model
    for (int i = 0; i < 200; i++) begin
      loadReq = ($urandom % 5) == 0;
      advanceN = $urandom % 2;
      modeIlv = $urandom % 2;
      extAddr = AW'($urandom);
      tick("R8");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule